// File: doc/BRIEF.md
# SCL Clock Timing Generator

This block paces the serial clock of a two-wire bus controller acting as master. It runs from a fast functional clock. A 16-bit baud count and a 2-bit speed code together set how many functional cycles SCL spends driven low and how many it spends released. While the block is enabled, SCL cycles continuously through three phases: a driven-low phase, a wait in which the line is released but has not yet been seen high, and a high phase. The high phase is timed only from the moment the line is sampled high. A target that holds SCL low therefore stretches the clock for exactly as long as it holds the line.

Two single-cycle strobes are given to the transaction sequencer. The sample strobe marks the middle of each high phase, which is the point at which SDA should be captured. The change strobe marks the point in each low phase at which SDA may be updated. A data setup timer delays the change strobe. It is armed with a programmable count in the cycle where the end of a stretch is seen, so the sequencer never moves SDA sooner than that many functional cycles after the target lets go of the clock.

Top module: `scl_timing_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `scl_pull_low`, `sample_stb` and `change_stb` are all 0.
- R2: With `speed_mode` = 0 (standard), each low phase lasts B cycles and each high phase lasts B cycles, where B is `baud_count`. The released time of an unstretched period is B+1 cycles, which includes one cycle spent seeing the line high.
- R3: With `speed_mode` = 1 (fast), each low phase lasts 2B cycles and each high phase lasts B cycles. This is a divider of 3 per period.
- R4: `speed_mode` codes 2 and 3 produce exactly the timing of code 0.
- R5: A `baud_count` of 0 produces the timing of a `baud_count` of 1.
- R6: After SCL is released, the high-phase count starts only in the cycle after `scl_in` is first sampled 1. With a target hold of W cycles, the released time of a period is W+1+H cycles, where H is the high-phase length.
- R7: `sample_stb` pulses exactly once per high phase. The pulse falls on high-phase count H/2, rounded down, which is released-time index W+1+H/2, and only while SCL is released and `scl_in` is 1.
- R8: `change_stb` pulses exactly once per low phase. The pulse falls on low-phase index max(0, S−H) when that index is below L, and on the last low cycle otherwise. S is `setup_count`, armed when the line is first seen high; L is the low-phase length.
- R9: Raising `enable` starts a low phase on the next cycle. Lowering `enable` releases SCL on the next cycle, and no strobe is issued while the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the SCL generator |
| speed_mode | input | 2 | 0 standard, 1 fast, 2 and 3 treated as standard |
| baud_count | input | 16 | Functional cycles per baud unit (0 acts as 1) |
| setup_count | input | 16 | Data setup cycles counted from the end of a stretch |
| scl_in | input | 1 | Sensed SCL line level, already synchronized |
| scl_pull_low | output | 1 | 1 drives SCL low, 0 releases it |
| sample_stb | output | 1 | One-cycle pulse: capture SDA now |
| change_stb | output | 1 | One-cycle pulse: SDA may change now |

## Verification
The checker assumes three things. First, `scl_in` is already synchronized to `clk`. Second, the target holds the line low only in the stretch that follows a release, never from the idle state and never during a high phase. Third, the speed code, baud count and setup count stay constant while `enable` is high. The bench respects all three: its target model clears its hold counter whenever the block is disabled, it starts a hold only when SCL is released, and it changes configuration only while `enable` is low. Every period is measured on the second low phase after enabling, so the setup timer has always been armed by a real release.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    localparam int BAUD_W  = 16;
    localparam int SETUP_W = 16;
    localparam int LEN_W   = BAUD_W + 1;

    typedef enum logic [1:0] {
        SPD_STD   = 2'd0,
        SPD_FAST  = 2'd1,
        SPD_FPLUS = 2'd2,
        SPD_HIGH  = 2'd3
    } spd_code_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

    typedef struct packed {
        logic [LEN_W-1:0] low_len;
        logic [LEN_W-1:0] high_len;
    } scl_period_t;

    function automatic logic [BAUD_W-1:0] baud_floor(input logic [BAUD_W-1:0] b);
        return (b == '0) ? BAUD_W'(1) : b;
    endfunction

    function automatic logic uses_long_low(input logic [1:0] code);
        return spd_code_e'(code) == SPD_FAST;
    endfunction

endpackage

// File: rtl/scl_period_calc.sv
module scl_period_calc
    import scl_gen_pkg::*;
(
    input  logic [1:0]        speed_mode,
    input  logic [BAUD_W-1:0] baud_count,
    output scl_period_t       period
);
    logic [BAUD_W-1:0] unit;

    always_comb begin
        unit            = baud_floor(baud_count);
        period.high_len = {1'b0, unit};
        if (uses_long_low(speed_mode))
            period.low_len = {unit, 1'b0};
        else
            period.low_len = {1'b0, unit};
    end
endmodule

// File: rtl/scl_setup_timer.sv
module scl_setup_timer
    import scl_gen_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               arm,
    input  logic [SETUP_W-1:0] setup_val,
    output logic               expired
);
    logic [SETUP_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || clear)
            remain <= '0;
        else if (arm)
            remain <= setup_val;
        else if (remain != '0)
            remain <= remain - SETUP_W'(1);
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/scl_strobe_gen.sv
module scl_strobe_gen
    import scl_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  scl_phase_e       phase,
    input  logic [LEN_W-1:0] count,
    input  scl_period_t      period,
    input  logic             setup_done,
    output logic             sample_stb,
    output logic             change_stb
);
    logic change_taken;

    always_comb begin
        sample_stb = (phase == PH_HIGH) && (count == (period.high_len >> 1));
        change_stb = (phase == PH_LOW) && !change_taken &&
                     (setup_done || (count == period.low_len - LEN_W'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst || phase != PH_LOW)
            change_taken <= 1'b0;
        else if (change_stb)
            change_taken <= 1'b1;
    end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_gen_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [1:0]         speed_mode,
    input  logic [BAUD_W-1:0]  baud_count,
    input  logic [SETUP_W-1:0] setup_count,
    input  logic               scl_in,
    output logic               scl_pull_low,
    output logic               sample_stb,
    output logic               change_stb
);
    scl_period_t      period;
    scl_phase_e       phase;
    logic [LEN_W-1:0] count;
    logic             setup_done;
    logic             arm_setup;

    scl_period_calc u_period (
        .speed_mode (speed_mode),
        .baud_count (baud_count),
        .period     (period)
    );

    assign arm_setup = enable && (phase == PH_WAIT) && scl_in;

    scl_setup_timer u_setup (
        .clk       (clk),
        .rst       (rst),
        .clear     (!enable),
        .arm       (arm_setup),
        .setup_val (setup_count),
        .expired   (setup_done)
    );

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            phase <= PH_IDLE;
            count <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    phase <= PH_LOW;
                    count <= '0;
                end
                PH_LOW: begin
                    if (count == period.low_len - LEN_W'(1)) begin
                        phase <= PH_WAIT;
                        count <= '0;
                    end else begin
                        count <= count + LEN_W'(1);
                    end
                end
                PH_WAIT: begin
                    if (scl_in) begin
                        phase <= PH_HIGH;
                        count <= '0;
                    end
                end
                default: begin
                    if (count == period.high_len - LEN_W'(1)) begin
                        phase <= PH_LOW;
                        count <= '0;
                    end else begin
                        count <= count + LEN_W'(1);
                    end
                end
            endcase
        end
    end

    assign scl_pull_low = (phase == PH_LOW);

    scl_strobe_gen u_strobe (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .count      (count),
        .period     (period),
        .setup_done (setup_done),
        .sample_stb (sample_stb),
        .change_stb (change_stb)
    );
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic scl_in,
    input logic scl_pull_low,
    input logic sample_stb,
    input logic change_stb
);
    // R1: outputs are quiet one cycle after any reset cycle
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!scl_pull_low && !sample_stb && !change_stb));

    // R8: SDA change is only offered while SCL is driven low
    p_change_in_low_r8: assert property (@(posedge clk) disable iff (rst)
        change_stb |-> scl_pull_low);

    // R8: at most one change strobe per low phase
    p_change_single_r8: assert property (@(posedge clk) disable iff (rst)
        change_stb |=> !change_stb);

    // R7: sampling happens only while released and seen high
    p_sample_high_r7: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> (!scl_pull_low && scl_in));

    // R6: while the target holds the line, SCL stays released
    p_stretch_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (enable && !scl_pull_low && !scl_in) |=> !scl_pull_low);

    // R9: disabling releases SCL on the next cycle
    p_disable_release_r9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!scl_pull_low && !sample_stb && !change_stb));
endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (.*);

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic [1:0]  speed_mode;
    logic [15:0] baud_count;
    logic [15:0] setup_count;
    logic        scl_in;
    logic        scl_pull_low;
    logic        sample_stb;
    logic        change_stb;

    int n_chk = 0;
    int n_err = 0;
    int stretch_w = 0;
    int hold_cnt;

    always #2 clk = ~clk;

    scl_timing_gen dut (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .speed_mode   (speed_mode),
        .baud_count   (baud_count),
        .setup_count  (setup_count),
        .scl_in       (scl_in),
        .scl_pull_low (scl_pull_low),
        .sample_stb   (sample_stb),
        .change_stb   (change_stb)
    );

    // target model: holds SCL low for stretch_w cycles after each release
    always_ff @(posedge clk) begin
        if (rst || !enable)      hold_cnt <= 0;
        else if (scl_pull_low)   hold_cnt <= stretch_w;
        else if (hold_cnt != 0)  hold_cnt <= hold_cnt - 1;
    end
    assign scl_in = !scl_pull_low && (hold_cnt == 0);

    // mode, baud, setup, stretch | low_len, released_len, change_idx, sample_idx
    localparam int NV = 9;
    localparam int VEC [NV][8] = '{
        '{0, 4,  0, 0,  4,  5, 0, 3},   // R2
        '{0, 4,  6, 0,  4,  5, 2, 3},   // R2 R8
        '{1, 3,  5, 0,  6,  4, 2, 2},   // R3 R8
        '{2, 3,  0, 0,  3,  4, 0, 2},   // R4
        '{3, 5, 20, 0,  5,  6, 4, 3},   // R4 R8 clamp to last low cycle
        '{0, 0,  0, 0,  1,  2, 0, 1},   // R5
        '{0, 4,  6, 5,  4, 10, 2, 8},   // R6 R8
        '{1, 2,  3, 3,  4,  6, 1, 5},   // R3 R6
        '{1, 0,  1, 0,  2,  2, 0, 1}    // R5 R3
    };

    int m_low, m_rel, m_chg_idx, m_samp_idx, m_chg_n, m_samp_n;

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic measure_period();
        while (scl_pull_low !== 1'b1) @(negedge clk);
        while (scl_pull_low === 1'b1) @(negedge clk);
        while (scl_pull_low !== 1'b1) @(negedge clk);
        m_low = 0; m_chg_idx = -1; m_chg_n = 0;
        while (scl_pull_low === 1'b1) begin
            if (change_stb) begin
                if (m_chg_idx < 0) m_chg_idx = m_low;
                m_chg_n++;
            end
            m_low++;
            @(negedge clk);
        end
        m_rel = 0; m_samp_idx = -1; m_samp_n = 0;
        while (scl_pull_low === 1'b0) begin
            if (sample_stb) begin
                if (m_samp_idx < 0) m_samp_idx = m_rel;
                m_samp_n++;
            end
            m_rel++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired, run hung");
        finish_run();
    end

    initial begin
        rst = 1'b1; enable = 1'b0;
        speed_mode = 2'd0; baud_count = 16'd4; setup_count = 16'd0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 scl_pull_low in reset", int'(scl_pull_low), 0);
        chk("R1 strobes in reset", int'(sample_stb | change_stb), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 released after reset while disabled", int'(scl_pull_low), 0);

        // R9 enable starts a low phase on the next cycle
        enable = 1'b1;
        @(negedge clk);
        chk("R9 low phase after enable", int'(scl_pull_low), 1);
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R9 release after disable", int'(scl_pull_low), 0);
        begin
            int quiet_hits = 0;
            for (int k = 0; k < 6; k++) begin
                if (scl_pull_low || sample_stb || change_stb) quiet_hits++;
                @(negedge clk);
            end
            chk("R9 no activity while disabled", quiet_hits, 0);
        end

        // vector table: R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            enable      = 1'b0;
            speed_mode  = 2'(VEC[v][0]);
            baud_count  = 16'(VEC[v][1]);
            setup_count = 16'(VEC[v][2]);
            stretch_w   = VEC[v][3];
            repeat (2) @(negedge clk);
            enable = 1'b1;
            measure_period();
            chk($sformatf("vec%0d low length R2 R3 R4 R5", v), m_low, VEC[v][4]);
            chk($sformatf("vec%0d released length R2 R6", v), m_rel, VEC[v][5]);
            chk($sformatf("vec%0d change index R8", v), m_chg_idx, VEC[v][6]);
            chk($sformatf("vec%0d change count R8", v), m_chg_n, 1);
            chk($sformatf("vec%0d sample index R7", v), m_samp_idx, VEC[v][7]);
            chk($sformatf("vec%0d sample count R7", v), m_samp_n, 1);
        end

        // R1 reset in mid-run returns outputs to rest
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-run reset releases SCL", int'(scl_pull_low), 0);
        rst = 1'b0;
        enable = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule